// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block turns one vector-prefixed operation into a stream of per-element issues, one element per clock. A start pulse captures the element count (a vector length times a length multiplier), a predicate mask, and, for the destination and two sources, a 5-bit register field with a scalar/vector flag. The block then walks the element indices in ascending order. For every element whose predicate bit is set it presents the element index and three physical 7-bit register indices with a valid strobe. An element whose predicate bit is clear uses one silent cycle.

Vector operands start at a base that the block gets by rotating the 5-bit field, so every vector base sits on a multiple of four. The index then steps by one per element. Scalar operands keep a fixed index. When the destination is scalar, the walk stops after the first enabled element. Together with a one-hot predicate this gives single-element extract and insert. A flag that comes with the done pulse tells when no element was issued, and in that case the scalar result is zero. There is no reduction. Every issued element writes its own destination element.

Top module: `vec_elem_seq`

## Requirements
- R1: A scalar operand (flag = 1) with field abcde maps to register 00abcde, and this stays the same for every element issued in the run.
- R2: A vector operand (flag = 0) with field abcde (a = bit 4) maps to base deabc00. For element k the issued index is (base + k) modulo 128.
- R3: Elements are visited in ascending index order from 0, and the issued element index goes up by one per visited element.
- R4: The number of elements visited is vl × vmul. An element whose index is 32 or more has no predicate bit and is treated as disabled.
- R5: An element whose predicate bit (bit k of pred for element k) is clear raises no iss_valid and takes exactly one cycle.
- R6: With a scalar destination the run ends after the first element whose predicate bit is set has been issued.
- R7: zero_res is high together with done exactly when the run issued no element. It is low at all other times.
- R8: done is a one-cycle pulse in the cycle after the last visited element, or after the terminating scalar-destination issue. busy is high from the cycle after an accepted start through the done cycle.
- R9: A start that arrives while busy is high, including the done cycle, is ignored and does not disturb the run in progress.
- R10: If vl × vmul is zero, done (with zero_res) comes in the cycle after start and no element is issued.
- R11: After reset, busy, iss_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; captures all operation inputs when idle |
| vl | input | 4 | Vector length |
| vmul | input | 2 | Length multiplier |
| pred | input | 32 | Predicate mask, bit k enables element k |
| rd_fld | input | 5 | Destination register field |
| rd_scl | input | 1 | Destination flag: 1 scalar, 0 vector |
| rs1_fld | input | 5 | First source register field |
| rs1_scl | input | 1 | First source flag: 1 scalar, 0 vector |
| rs2_fld | input | 5 | Second source register field |
| rs2_scl | input | 1 | Second source flag: 1 scalar, 0 vector |
| busy | output | 1 | Run in progress (through the done cycle) |
| iss_valid | output | 1 | An element operation is issued this cycle |
| iss_elem | output | 6 | Element index of the current cycle |
| iss_rd | output | 7 | Physical destination register index |
| iss_rs1 | output | 7 | Physical first source register index |
| iss_rs2 | output | 7 | Physical second source register index |
| done | output | 1 | One-cycle end-of-run pulse |
| zero_res | output | 1 | With done: no element was issued |

## Verification
Two end conditions can land on the same cycle: the early stop for a scalar destination and the natural end at the last element. The bench causes this by enabling only the final element under a scalar destination. It expects one issue on that element, then a single done pulse with zero_res low and no extra cycle. The bench also sends start pulses inside a run and in the done cycle itself, and judges them by an unchanged issue trace followed by an idle block. A behavioural model builds each run's expected per-cycle trace and compares it with the outputs on every clock.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int FIELD_W = 5;
  localparam int REG_W   = FIELD_W + 2;
  localparam int NUM_OPS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // scalar: zero-extended field; vector: rotate low two bits to the top, times 4
  function automatic logic [REG_W-1:0] base_of(input logic [FIELD_W-1:0] fld,
                                               input logic scl);
    if (scl) base_of = {2'b00, fld};
    else     base_of = {fld[1:0], fld[FIELD_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/vseq_reg_map.sv
module vseq_reg_map
  import vseq_pkg::*;
#(
  parameter int ELEM_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] fld,
  input  logic               scl,
  input  logic [ELEM_W-1:0]  elem,
  output logic [REG_W-1:0]   reg_idx
);
  logic [REG_W-1:0] base;
  logic [REG_W-1:0] step;

  always_comb begin
    base    = base_of(fld, scl);
    step    = scl ? '0 : REG_W'(elem);
    reg_idx = base + step;
  end

  // R1: a held scalar operand never moves with the element index
  a_r1_scalar_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $stable(scl) && $stable(fld)) |-> $stable(reg_idx));

  // R2: vector bases are aligned to multiples of four at element 0
  a_r2_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl && elem == '0) |-> (reg_idx[1:0] == 2'b00));
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int VL_W   = 4,
  parameter int MUL_W  = 2,
  parameter int PRED_W = 32,
  localparam int ELEM_W = VL_W + MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [MUL_W-1:0]  vmul,
  input  logic [PRED_W-1:0] pred,
  input  logic              dst_scl,
  output logic              accept,
  output logic              busy,
  output logic              iss_valid,
  output logic [ELEM_W-1:0] elem,
  output logic              done,
  output logic              zero_res
);
  seq_state_e        st_q, st_d;
  logic [ELEM_W-1:0] idx_q, idx_d;
  logic [ELEM_W-1:0] tot_q, tot_d;
  logic [PRED_W-1:0] pred_q;
  logic              dscl_q;
  logic              any_q, any_d;
  logic              pred_bit;
  logic              last;

  always_comb begin
    tot_d = ELEM_W'(vl) * ELEM_W'(vmul);
    pred_bit = 1'b0;
    for (int i = 0; i < PRED_W; i++) begin
      if (idx_q == ELEM_W'(i)) pred_bit = pred_q[i];
    end
    last = (idx_q == tot_q - ELEM_W'(1));
  end

  assign busy      = (st_q != ST_IDLE);
  assign iss_valid = (st_q == ST_RUN) && pred_bit;
  assign elem      = idx_q;
  assign done      = (st_q == ST_FIN);
  assign zero_res  = (st_q == ST_FIN) && !any_q;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    any_d  = any_q;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          idx_d  = '0;
          any_d  = 1'b0;
          st_d   = (tot_d == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (iss_valid) any_d = 1'b1;
        if ((iss_valid && dscl_q) || last) st_d = ST_FIN;
        else                               idx_d = idx_q + ELEM_W'(1);
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      any_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      any_q <= any_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      pred_q <= '0;
      dscl_q <= 1'b0;
    end else if (accept) begin
      tot_q  <= tot_d;
      pred_q <= pred;
      dscl_q <= dst_scl;
    end
  end

  // R8: done lasts exactly one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a scalar destination issue is followed by the end of the run
  a_r6_scalar_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dscl_q) |=> done);
  // R7: the zero flag only appears with done
  a_r7_zero_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    zero_res |-> done);
  // R9: captured length is left alone by a start during a run
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tot_q));
  // R5: issue only happens inside a run
  a_r5_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (busy && !done));
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int VL_W   = 4,
  parameter int MUL_W  = 2,
  parameter int PRED_W = 32,
  localparam int ELEM_W = VL_W + MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [MUL_W-1:0]  vmul,
  input  logic [PRED_W-1:0] pred,
  input  logic [4:0]        rd_fld,
  input  logic              rd_scl,
  input  logic [4:0]        rs1_fld,
  input  logic              rs1_scl,
  input  logic [4:0]        rs2_fld,
  input  logic              rs2_scl,
  output logic              busy,
  output logic              iss_valid,
  output logic [ELEM_W-1:0] iss_elem,
  output logic [6:0]        iss_rd,
  output logic [6:0]        iss_rs1,
  output logic [6:0]        iss_rs2,
  output logic              done,
  output logic              zero_res
);
  logic [NUM_OPS-1:0][FIELD_W-1:0] fld_in, fld_q;
  logic [NUM_OPS-1:0]              scl_in, scl_q;
  logic [NUM_OPS-1:0][REG_W-1:0]   map_idx;
  logic                            accept;

  assign fld_in = {rs2_fld, rs1_fld, rd_fld};
  assign scl_in = {rs2_scl, rs1_scl, rd_scl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
      scl_q <= '0;
    end else if (accept) begin
      fld_q <= fld_in;
      scl_q <= scl_in;
    end
  end

  vseq_ctrl #(.VL_W(VL_W), .MUL_W(MUL_W), .PRED_W(PRED_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vl       (vl),
    .vmul     (vmul),
    .pred     (pred),
    .dst_scl  (rd_scl),
    .accept   (accept),
    .busy     (busy),
    .iss_valid(iss_valid),
    .elem     (iss_elem),
    .done     (done),
    .zero_res (zero_res)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    vseq_reg_map #(.ELEM_W(ELEM_W)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .fld    (fld_q[g]),
      .scl    (scl_q[g]),
      .elem   (iss_elem),
      .reg_idx(map_idx[g])
    );
  end

  assign iss_rd  = map_idx[0];
  assign iss_rs1 = map_idx[1];
  assign iss_rs2 = map_idx[2];

  // R3: back-to-back issues move strictly forward in element order
  a_r3_elem_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid)) |-> (iss_elem > $past(iss_elem)));
endmodule

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  vl;
  logic [1:0]  vmul;
  logic [31:0] pred;
  logic [4:0]  rd_fld, rs1_fld, rs2_fld;
  logic        rd_scl, rs1_scl, rs2_scl;
  logic        busy, iss_valid, done, zero_res;
  logic [5:0]  iss_elem;
  logic [6:0]  iss_rd, iss_rs1, iss_rs2;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_elem_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .vmul(vmul), .pred(pred),
    .rd_fld(rd_fld), .rd_scl(rd_scl), .rs1_fld(rs1_fld), .rs1_scl(rs1_scl),
    .rs2_fld(rs2_fld), .rs2_scl(rs2_scl), .busy(busy), .iss_valid(iss_valid),
    .iss_elem(iss_elem), .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
    .done(done), .zero_res(zero_res)
  );

  // expected register index from the requirement text
  function automatic int emap(int fld, bit scl, int k);
    int b;
    if (scl) return fld;
    b = ((fld & 3) * 32) + ((fld / 4) * 4);
    return (b + k) % 128;
  endfunction

  int q_val[$], q_elem[$], q_rd[$], q_rs1[$], q_rs2[$], q_done[$], q_zero[$];

  task automatic build(int v, int m, logic [31:0] p, int f0, bit s0,
                       int f1, bit s1, int f2, bit s2);
    int any = 0;
    q_val = {}; q_elem = {}; q_rd = {}; q_rs1 = {}; q_rs2 = {}; q_done = {}; q_zero = {};
    for (int k = 0; k < v * m; k++) begin
      int en = (k < 32) ? int'(p[k]) : 0;
      q_val.push_back(en); q_elem.push_back(k);
      q_rd.push_back(emap(f0, s0, k)); q_rs1.push_back(emap(f1, s1, k));
      q_rs2.push_back(emap(f2, s2, k));
      q_done.push_back(0); q_zero.push_back(0);
      if (en != 0) any = 1;
      if (en != 0 && s0) break;
    end
    q_val.push_back(0); q_elem.push_back(0); q_rd.push_back(0);
    q_rs1.push_back(0); q_rs2.push_back(0);
    q_done.push_back(1); q_zero.push_back(any == 0 ? 1 : 0);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ign_at: trace step in which a stray start (with other inputs) is driven
  task automatic run_op(string tag, int v, int m, logic [31:0] p,
                        int f0, bit s0, int f1, bit s1, int f2, bit s2, int ign_at);
    build(v, m, p, f0, s0, f1, s1, f2, s2);
    @(negedge clk);
    start = 1'b1; vl = 4'(v); vmul = 2'(m); pred = p;
    rd_fld = 5'(f0); rd_scl = s0; rs1_fld = 5'(f1); rs1_scl = s1;
    rs2_fld = 5'(f2); rs2_scl = s2;
    for (int j = 0; j < q_val.size(); j++) begin
      @(negedge clk);
      start = (j == ign_at);
      if (j == ign_at) begin
        vl = 4'd9; vmul = 2'd2; pred = ~p; rd_scl = ~s0; rd_fld = 5'(f0 + 3);
      end
      check(busy == 1'b1, tag, "busy", int'(busy), 1);
      check(int'(iss_valid) == q_val[j], tag, "iss_valid", int'(iss_valid), q_val[j]);
      if (q_val[j] != 0) begin
        check(int'(iss_elem) == q_elem[j], tag, "iss_elem", int'(iss_elem), q_elem[j]);
        check(int'(iss_rd) == q_rd[j], tag, "iss_rd", int'(iss_rd), q_rd[j]);
        check(int'(iss_rs1) == q_rs1[j], tag, "iss_rs1", int'(iss_rs1), q_rs1[j]);
        check(int'(iss_rs2) == q_rs2[j], tag, "iss_rs2", int'(iss_rs2), q_rs2[j]);
      end
      check(int'(done) == q_done[j], tag, "done", int'(done), q_done[j]);
      check(int'(zero_res) == q_zero[j], tag, "zero_res", int'(zero_res), q_zero[j]);
    end
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done && !iss_valid, tag, "idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = '0; vmul = '0; pred = '0;
    rd_fld = '0; rs1_fld = '0; rs2_fld = '0; rd_scl = 0; rs1_scl = 0; rs2_scl = 0;
    repeat (3) @(negedge clk);
    check(!busy && !iss_valid && !done, "R11", "reset idle", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !iss_valid && !done, "R11", "idle after reset", int'(busy), 0);

    // R2 R3: all-vector, all enabled
    run_op("R2", 4, 1, 32'hFFFF_FFFF, 5'b10110, 0, 5'b00011, 0, 5'b11111, 0, -1);
    // R1 R5: scalar sources, sparse mask
    run_op("R5", 3, 2, 32'h0000_00A6, 5'b01001, 0, 5'b10101, 1, 5'b00111, 1, -1);
    // R6: one-hot extract on element 5 under a scalar destination
    run_op("R6", 8, 1, 32'h0000_0020, 5'b00100, 1, 5'b01100, 0, 5'b00001, 1, -1);
    // R6 R8: enabled element is the very last one
    run_op("R8", 4, 1, 32'h0000_0008, 5'b11000, 1, 5'b00010, 0, 5'b00110, 0, -1);
    // R7: scalar destination, nothing enabled
    run_op("R7", 5, 1, 32'h0, 5'b00001, 1, 5'b00010, 0, 5'b00011, 0, -1);
    // R7: vector destination, nothing enabled
    run_op("R7", 2, 3, 32'h0, 5'b01111, 0, 5'b00010, 0, 5'b00011, 1, -1);
    // R10: zero length and zero multiplier
    run_op("R10", 0, 3, 32'hFFFF_FFFF, 5'b00101, 0, 5'b00010, 0, 5'b00011, 0, -1);
    run_op("R10", 7, 0, 32'hFFFF_FFFF, 5'b00101, 1, 5'b00010, 0, 5'b00011, 0, -1);
    // R4: 45 elements, indices 32 and up disabled, index wrap
    run_op("R4", 15, 3, 32'hFFFF_FFFF, 5'b11111, 0, 5'b11110, 0, 5'b10001, 1, -1);
    // R9: stray start mid-run and in the done cycle
    run_op("R9", 6, 1, 32'h0000_0035, 5'b01010, 0, 5'b00101, 1, 5'b10010, 0, 2);
    run_op("R9", 3, 1, 32'h0000_0007, 5'b01011, 0, 5'b00100, 0, 5'b10011, 1, 3);
    // R1 R6: scalar destination with first element enabled
    run_op("R1", 4, 2, 32'h0000_00FF, 5'b10101, 1, 5'b10101, 1, 5'b01010, 0, -1);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule